// File: doc/BRIEF.md
# Receive Descriptor Write-Back Engine

The engine stores each received Ethernet frame across a ring of receive buffers, each `buf_size` bytes long. A buffer is described by an 8-byte descriptor in memory. For every buffer the engine reads the descriptor, accepts up to one buffer's worth of bytes from the MAC-side stream, and then writes the descriptor back at once. The write-back hands that buffer to software before the engine moves on to the next descriptor. The engine does not wait until the whole frame has landed.

Descriptor layout, as a 64-bit little-endian value: bit 0 is the ownership bit (1 means software owns the buffer), bit 1 is the wrap marker, and bits [31:2] hold the buffer address. Bits [45:32] hold the length field, bit 46 marks start of frame and bit 47 marks end of frame. Software programs the ring base and the buffer size as plain inputs. A frame is announced by a one-cycle `frm_start` pulse carrying its length, and its bytes then follow on a valid/ready stream. Status flags and the interrupt are sticky and are cleared by write-1 pulses.

Top module: `rx_desc_wb`

## Requirements
- R1: A frame longer than one buffer is split over consecutive descriptors. Each descriptor takes at most `buf_size` bytes, and only the last one takes fewer.
- R2: The first descriptor of a frame is written back with bit 46 (start) set. A frame that fits in one buffer sets both bit 46 and bit 47 in that one descriptor.
- R3: The descriptor holding the final chunk gets bit 47 (end) set and the total frame length in bits [45:32]. Earlier descriptors keep their length field unchanged.
- R4: Every descriptor written back has bit 0 (ownership) set, and its other word-0 bits are unchanged.
- R5: A descriptor is written back right after its buffer is filled. This happens before the next descriptor is fetched and before any further byte is accepted, so that earlier buffers of a frame already belong to software while the frame is still arriving.
- R6: The descriptor pointer starts at `ring_base` after reset and advances by 8 after each descriptor used. A descriptor with bit 1 (wrap) set sends the pointer back to `ring_base`.
- R7: `stat_frm_rcvd` is set once the last descriptor of a frame has been written back.
- R8: `irq_rx_done` is set at frame completion only if `irq_mask` is 0 at that time.
- R9: If a fetched descriptor already has bit 0 set, the engine sets `stat_bna`, accepts and discards the rest of the frame, writes no descriptor, does not advance the pointer and does not set `stat_frm_rcvd`.
- R10: Status and interrupt flags stay set until cleared by a 1 on `status_clr[0]` (frame received), `status_clr[1]` (buffer not available) or `irq_clr`. A new set event in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_base | input | ADDR_W | Address of the first descriptor of the ring, 8-byte aligned |
| buf_size | input | LEN_W | Bytes per receive buffer, at least 1 |
| irq_mask | input | 1 | 1 suppresses the receive-complete interrupt |
| status_clr | input | 2 | Write-1 clear: bit 0 frame received, bit 1 buffer not available |
| irq_clr | input | 1 | Write-1 clear of the interrupt flag |
| frm_start | input | 1 | One-cycle pulse announcing a frame, taken while idle |
| frm_len | input | LEN_W | Frame length in bytes, at least 1 |
| in_valid | input | 1 | A frame byte is offered |
| in_ready | output | 1 | The engine accepts the offered byte this cycle |
| mem_req | output | 1 | Descriptor memory request, held until `mem_rvalid` |
| mem_we | output | 1 | 1 for a write-back, 0 for a fetch |
| mem_addr | output | ADDR_W | Descriptor address |
| mem_wdata | output | 64 | Descriptor written back |
| mem_rvalid | input | 1 | Response: completes the pending request |
| mem_rdata | input | 64 | Descriptor read, valid with `mem_rvalid` on a fetch |
| stat_frm_rcvd | output | 1 | Sticky frame-received flag |
| stat_bna | output | 1 | Sticky buffer-not-available flag |
| irq_rx_done | output | 1 | Sticky receive-complete interrupt |

## Verification
The assertions rely on the memory answering each request exactly once with `mem_rvalid` and never asserting it without a pending request. They also assume `buf_size` and `frm_len` are nonzero and that `ring_base` is 8-byte aligned and stable while frames are in flight. The bench memory model raises `mem_rvalid` for one cycle, one cycle after each request, and only in answer to a pending request. The scenarios keep the buffer size at 64 and use frame lengths between 5 and 150. The bench announces a frame only when the engine is idle, after the previous frame has fully drained.

// File: rtl/rx_desc_wb_pkg.sv
package rx_desc_wb_pkg;
    localparam int DESC_W      = 64;
    localparam int DESC_STEP   = 8;
    localparam int OWN_POS     = 0;
    localparam int WRAP_POS    = 1;
    localparam int LENF_LSB    = 32;
    localparam int LENF_W      = 14;
    localparam int SOF_POS     = 46;
    localparam int EOF_POS     = 47;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_FILL,
        ST_WBACK,
        ST_DROP
    } rx_state_e;
endpackage

// File: rtl/rx_desc_fmt.sv
module rx_desc_fmt
    import rx_desc_wb_pkg::*;
#(
    parameter int LEN_W = 14
) (
    input  logic [DESC_W-1:0] desc_in,
    input  logic              is_first,
    input  logic              is_last,
    input  logic [LEN_W-1:0]  total_len,
    output logic [DESC_W-1:0] desc_out
);
    localparam int PAD_W = LENF_W - LEN_W;

    logic [LENF_W-1:0] len_field;

    generate
        if (PAD_W > 0) begin : g_pad
            assign len_field = {{PAD_W{1'b0}}, total_len};
        end else begin : g_nopad
            assign len_field = total_len[LENF_W-1:0];
        end
    endgenerate

    always_comb begin
        desc_out          = desc_in;
        desc_out[OWN_POS] = 1'b1;
        if (is_first) begin
            desc_out[SOF_POS] = 1'b1;
        end
        if (is_last) begin
            desc_out[EOF_POS]                = 1'b1;
            desc_out[LENF_LSB +: LENF_W]     = len_field;
        end
    end
endmodule

// File: rtl/rx_desc_ptr_next.sv
module rx_desc_ptr_next
    import rx_desc_wb_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] cur_ptr,
    input  logic [ADDR_W-1:0] base_ptr,
    input  logic              wrap,
    output logic [ADDR_W-1:0] next_ptr
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(DESC_STEP);

    always_comb begin
        if (wrap) begin
            next_ptr = base_ptr;
        end else begin
            next_ptr = cur_ptr + STEP;
        end
    end
endmodule

// File: rtl/rx_desc_wb.sv
module rx_desc_wb
    import rx_desc_wb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] ring_base,
    input  logic [LEN_W-1:0]  buf_size,
    input  logic              irq_mask,
    input  logic [1:0]        status_clr,
    input  logic              irq_clr,
    input  logic              frm_start,
    input  logic [LEN_W-1:0]  frm_len,
    input  logic              in_valid,
    output logic              in_ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DESC_W-1:0] mem_wdata,
    input  logic              mem_rvalid,
    input  logic [DESC_W-1:0] mem_rdata,
    output logic              stat_frm_rcvd,
    output logic              stat_bna,
    output logic              irq_rx_done
);
    localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

    typedef struct packed {
        rx_state_e         st;
        logic [ADDR_W-1:0] ptr;
        logic              ptr_ok;
        logic [DESC_W-1:0] desc;
        logic [LEN_W-1:0]  total;
        logic [LEN_W-1:0]  left;
        logic [LEN_W-1:0]  chunk;
        logic              first;
        logic              frm;
        logic              bna;
        logic              irq;
    } regs_t;

    regs_t r_q, r_d;

    logic [DESC_W-1:0] wb_desc;
    logic [ADDR_W-1:0] ptr_adv;
    logic              last_chunk;

    assign last_chunk = (r_q.left == '0);

    rx_desc_fmt #(.LEN_W(LEN_W)) i_fmt (
        .desc_in   (r_q.desc),
        .is_first  (r_q.first),
        .is_last   (last_chunk),
        .total_len (r_q.total),
        .desc_out  (wb_desc)
    );

    rx_desc_ptr_next #(.ADDR_W(ADDR_W)) i_ptr (
        .cur_ptr  (r_q.ptr),
        .base_ptr (ring_base),
        .wrap     (r_q.desc[WRAP_POS]),
        .next_ptr (ptr_adv)
    );

    always_comb begin
        r_d       = r_q;
        in_ready  = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = r_q.ptr;
        mem_wdata = wb_desc;

        if (status_clr[0]) r_d.frm = 1'b0;
        if (status_clr[1]) r_d.bna = 1'b0;
        if (irq_clr)       r_d.irq = 1'b0;

        unique case (r_q.st)
            ST_IDLE: begin
                if (frm_start && (frm_len != '0)) begin
                    r_d.total = frm_len;
                    r_d.left  = frm_len;
                    r_d.first = 1'b1;
                    r_d.st    = ST_FETCH;
                    if (!r_q.ptr_ok) begin
                        r_d.ptr    = ring_base;
                        r_d.ptr_ok = 1'b1;
                    end
                end
            end
            ST_FETCH: begin
                mem_req = 1'b1;
                if (mem_rvalid) begin
                    r_d.desc  = mem_rdata;
                    r_d.chunk = '0;
                    if (mem_rdata[OWN_POS]) begin
                        r_d.bna = 1'b1;
                        r_d.st  = ST_DROP;
                    end else begin
                        r_d.st  = ST_FILL;
                    end
                end
            end
            ST_FILL: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    r_d.left  = r_q.left - ONE;
                    r_d.chunk = r_q.chunk + ONE;
                    if ((r_q.left == ONE) || (r_q.chunk + ONE == buf_size)) begin
                        r_d.st = ST_WBACK;
                    end
                end
            end
            ST_WBACK: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                if (mem_rvalid) begin
                    r_d.ptr   = ptr_adv;
                    r_d.first = 1'b0;
                    if (last_chunk) begin
                        r_d.st  = ST_IDLE;
                        r_d.frm = 1'b1;
                        if (!irq_mask) r_d.irq = 1'b1;
                    end else begin
                        r_d.st  = ST_FETCH;
                    end
                end
            end
            ST_DROP: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    r_d.left = r_q.left - ONE;
                    if (r_q.left == ONE) r_d.st = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q        <= '0;
            r_q.st     <= ST_IDLE;
        end else begin
            r_q        <= r_d;
        end
    end

    assign stat_frm_rcvd = r_q.frm;
    assign stat_bna      = r_q.bna;
    assign irq_rx_done   = r_q.irq;

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R5
    AST_WB_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_wdata[OWN_POS] && (mem_wdata[31:1] == r_q.desc[31:1]))); // R4
    AST_NO_BYTES_DURING_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !in_ready); // R5
    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_rvalid) |=>
        ((mem_addr == $past(mem_addr) + ADDR_W'(DESC_STEP)) || (mem_addr == $past(ring_base)))); // R6
    AST_EOF_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_wdata[EOF_POS]) |->
        (mem_wdata[LENF_LSB +: LEN_W] == r_q.total)); // R3
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_rx_done) |-> !$past(irq_mask)); // R8
    AST_FRM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stat_frm_rcvd) |-> $past(status_clr[0])); // R10
    AST_DROP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_bna) |-> !mem_req); // R9
endmodule

// File: tb/test_rx_desc_wb.sv
module test_rx_desc_wb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] ring_base = 32'h0000_1000;
    logic [13:0] buf_size = 14'd64;
    logic        irq_mask = 1'b0;
    logic [1:0]  status_clr = 2'b00;
    logic        irq_clr = 1'b0;
    logic        frm_start = 1'b0;
    logic [13:0] frm_len = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr;
    logic [63:0] mem_wdata;
    logic        mem_rvalid = 1'b0;
    logic [63:0] mem_rdata = '0;
    logic        stat_frm_rcvd, stat_bna, irq_rx_done;

    logic [63:0] dmem [16];
    logic        sw_we = 1'b0;
    logic [3:0]  sw_idx = '0;
    logic [63:0] sw_data = '0;
    logic [63:0] snap1, snap3;
    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    rx_desc_wb i_rx_desc_wb (
        .clk(clk), .rst_n(rst_n), .ring_base(ring_base), .buf_size(buf_size),
        .irq_mask(irq_mask), .status_clr(status_clr), .irq_clr(irq_clr),
        .frm_start(frm_start), .frm_len(frm_len), .in_valid(in_valid),
        .in_ready(in_ready), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .stat_frm_rcvd(stat_frm_rcvd),
        .stat_bna(stat_bna), .irq_rx_done(irq_rx_done)
    );

    always @(posedge clk) begin
        if (sw_we) dmem[sw_idx] <= sw_data;
        if (mem_req && !mem_rvalid) begin
            if (mem_we) dmem[mem_addr[6:3]] <= mem_wdata;
            mem_rdata <= dmem[mem_addr[6:3]];
        end
        mem_rvalid <= mem_req && !mem_rvalid;
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic sw_write(input int idx, input logic [63:0] val);
        @(negedge clk); sw_we = 1'b1; sw_idx = 4'(idx); sw_data = val;
        @(negedge clk); sw_we = 1'b0;
    endtask

    task automatic send_frame(input int len, input int probe_at);
        int sent = 0;
        @(negedge clk); frm_start = 1'b1; frm_len = 14'(len);
        @(negedge clk); frm_start = 1'b0;
        while (sent < len) begin
            in_valid = 1'b1;
            if (in_ready) sent++;
            if (sent == probe_at) begin snap1 = dmem[1]; snap3 = dmem[3]; end
            @(negedge clk);
        end
        in_valid = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic clear_all();
        @(negedge clk); status_clr = 2'b11; irq_clr = 1'b1;
        @(negedge clk); status_clr = 2'b00; irq_clr = 1'b0;
    endtask

    function automatic logic [63:0] dsc(input int idx, input logic [31:0] w1, input logic [1:0] flags);
        return {w1, 32'h0000_8000 + 32'(idx) * 32'h100 + {30'd0, flags}};
    endfunction

    task automatic t_reset();
        chk("R6 reset in_ready", {63'd0, in_ready}, 64'd0);
        chk("R6 reset mem_req", {63'd0, mem_req}, 64'd0);
        chk("R10 reset flags", {61'd0, stat_frm_rcvd, stat_bna, irq_rx_done}, 64'd0);
    endtask

    task automatic t_single();
        send_frame(40, -1);
        chk("R2 single sof+eof", dmem[0], dsc(0, 32'h0000_C028, 2'b01));
        chk("R6 next untouched", dmem[1], dsc(1, 0, 2'b00));
        chk("R7 frame received", {63'd0, stat_frm_rcvd}, 64'd1);
        chk("R8 irq unmasked", {63'd0, irq_rx_done}, 64'd1);
        repeat (20) @(negedge clk);
        chk("R10 sticky", {62'd0, stat_frm_rcvd, irq_rx_done}, 64'd3);
        clear_all();
        chk("R10 w1c clear", {61'd0, stat_frm_rcvd, stat_bna, irq_rx_done}, 64'd0);
    endtask

    task automatic t_multi();
        send_frame(150, 100);
        chk("R5 first owned mid-frame", {63'd0, snap1[0]}, 64'd1);
        chk("R5 last not yet owned", {63'd0, snap3[0]}, 64'd0);
        chk("R2 R1 first chunk", dmem[1], dsc(1, 32'h0000_4000, 2'b01));
        chk("R4 R1 middle chunk", dmem[2], dsc(2, 0, 2'b01));
        chk("R3 last chunk", dmem[3], dsc(3, 32'h0000_8096, 2'b01));
        chk("R1 no extra desc", dmem[4], dsc(4, 0, 2'b00));
        clear_all();
    endtask

    task automatic t_exact();
        send_frame(128, -1);
        chk("R1 exact first", dmem[4], dsc(4, 32'h0000_4000, 2'b01));
        chk("R3 exact last", dmem[5], dsc(5, 32'h0000_8080, 2'b01));
        chk("R1 exact no spill", dmem[6], dsc(6, 0, 2'b00));
        clear_all();
    endtask

    task automatic t_wrap_bna();
        sw_write(6, dsc(6, 0, 2'b10));
        send_frame(10, -1);
        chk("R4 wrap kept", dmem[6], dsc(6, 32'h0000_C00A, 2'b11));
        clear_all();
        send_frame(20, -1);
        chk("R9 bna set", {63'd0, stat_bna}, 64'd1);
        chk("R9 no frame rcvd", {63'd0, stat_frm_rcvd}, 64'd0);
        chk("R9 desc unchanged", dmem[0], dsc(0, 32'h0000_C028, 2'b01));
        chk("R9 neighbour unchanged", dmem[1], dsc(1, 32'h0000_4000, 2'b01));
    endtask

    task automatic t_masked();
        sw_write(0, dsc(0, 0, 2'b00));
        irq_mask = 1'b1;
        send_frame(5, -1);
        chk("R6 wrapped to base", dmem[0], dsc(0, 32'h0000_C005, 2'b01));
        chk("R7 frame received", {63'd0, stat_frm_rcvd}, 64'd1);
        chk("R8 masked irq", {63'd0, irq_rx_done}, 64'd0);
        chk("R10 bna sticky", {63'd0, stat_bna}, 64'd1);
        irq_mask = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 16; i++) dmem[i] = dsc(i, 0, 2'b00);
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_single();
        t_multi();
        t_exact();
        t_wrap_bna();
        t_masked();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R5 watchdog actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule